// File: doc/BRIEF.md
# Broadcast Storm Suppression Filter

This block sits on the receive side of one switch port and decides, frame by frame, whether a received frame should be discarded because it belongs to a broadcast storm. For every frame presented with a valid strobe, it looks at the destination address and decides whether the frame is a broadcast. It keeps a saturating count of broadcasts received back to back. Once that run is longer than a fixed limit, further broadcasts are marked for dropping. Frames to any other address always pass.

The run count is cleared in two ways. A frame with any other destination address clears it. So does a periodic window, built by dividing an external time-base tick by a parameter; the default is 800 ticks of 1 ms, giving an 800 ms period. The whole filter is switched on or off by a strap input. The strap is sampled only while reset is asserted, so changing it later has no effect. Each decision is registered and appears exactly one clock after its frame.

Top module: `bcast_storm_filter`

## Requirements
- R1: The enable strap is captured on every clock edge while `rst` is high. If the captured value is 0, `dec_drop` is never 1.
- R2: Changes of `strap_en` while `rst` is low do not change the filter's behaviour.
- R3: A frame is a broadcast only when all `ADDR_W` bits of `frm_da` are 1. An address with any single bit at 0 is treated as non-broadcast.
- R4: With the filter enabled, the first `RUN_LIMIT` broadcasts of a run pass (`dec_drop`=0). Every later broadcast of the same run is dropped (`dec_drop`=1).
- R5: A non-broadcast frame is never dropped. It resets the run count to zero, so the next broadcast is the first of a new run.
- R6: The run count saturates at `RUN_LIMIT` and never wraps. Any number of broadcasts beyond the limit all stay dropped.
- R7: Every `WINDOW_TICKS`-th cycle with `tick`=1 after reset clears the run count. Cycles with `tick`=0 do not advance the window.
- R8: When a window clear falls in the same cycle as a broadcast frame, the clear is applied first. That broadcast passes and counts as the first of a new run.
- R9: `dec_valid` is 1 exactly in the cycle after a cycle with `frm_valid`=1. `dec_drop` is 0 whenever `dec_valid` is 0.
- R10: While and right after reset, `dec_valid` and `dec_drop` are 0. Reset clears both the run count and the window position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_en | input | 1 | Filter enable, sampled during reset |
| tick | input | 1 | Time-base pulse, one cycle wide |
| frm_valid | input | 1 | A frame's destination address is present |
| frm_da | input | ADDR_W | Destination address of the frame |
| dec_valid | output | 1 | Decision present (one cycle after frm_valid) |
| dec_drop | output | 1 | Decision: 1 drops the frame |

## Verification
The two functions that can meet in one cycle are the window clear and the counting of a broadcast frame. The bench provokes this in two ways. First, it fills a run to the limit with the tick held low. It then raises `tick` on the window's last position in the same cycle as a broadcast. Second, it streams broadcasts with `tick` high in every cycle, so clears land on frames again and again. The result is judged against an arithmetic model in the bench. That model applies the clear before the increment, so the colliding broadcast must pass and the run must restart at one.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  // Registered per-frame verdict.
  typedef struct packed {
    logic valid;
    logic drop;
  } bsf_verdict_t;

  // Width needed to hold values 0..n (at least one bit).
  function automatic int bsf_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/bsf_addr_class.sv
module bsf_addr_class #(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_bcast
);
  localparam int NBYTES = ADDR_W / 8;

  logic [NBYTES-1:0] byte_all_ones;

  // One reduction per address octet, then a final AND across octets.
  for (genvar g = 0; g < NBYTES; g++) begin : g_octet
    assign byte_all_ones[g] = &addr[g*8 +: 8];
  end

  assign is_bcast = &byte_all_ones;

  initial begin
    a_r3_octet_width : assert (ADDR_W % 8 == 0 && ADDR_W >= 8);
  end
endmodule

// File: rtl/bsf_window.sv
module bsf_window #(
  parameter int WINDOW_TICKS = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic win_clear
);
  import bsf_pkg::*;

  localparam int TW = bsf_width(WINDOW_TICKS);
  localparam logic [TW-1:0] LAST = TW'(WINDOW_TICKS - 1);

  logic [TW-1:0] pos_q;

  // Clear is raised on the tick that completes a window.
  assign win_clear = tick && (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            pos_q <= '0;
    else if (win_clear) pos_q <= '0;
    else if (tick)      pos_q <= pos_q + 1'b1;
  end

  // R7: window position stays inside its period
  a_r7_pos_in_range : assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST);

  // R7: without a tick the window does not move
  a_r7_hold_no_tick : assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pos_q));
endmodule

// File: rtl/bsf_run_counter.sv
module bsf_run_counter #(
  parameter int RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic win_clear,
  input  logic frame_valid,
  input  logic frame_bcast,
  output logic over_limit
);
  import bsf_pkg::*;

  localparam int CW = bsf_width(RUN_LIMIT);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LIMIT);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_eff;
  logic [CW-1:0] run_nxt;

  // A window clear is applied before this cycle's frame is counted.
  assign run_eff    = win_clear ? '0 : run_q;
  assign over_limit = (run_eff == LIMIT);

  always_comb begin
    run_nxt = run_eff;
    if (frame_valid) begin
      if (!frame_bcast)           run_nxt = '0;
      else if (run_eff != LIMIT)  run_nxt = run_eff + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_nxt;
  end

  // R6: the count never exceeds the limit
  a_r6_no_wrap : assert property (@(posedge clk) disable iff (rst)
    run_q <= LIMIT);

  // R6: a saturated count stays saturated under more broadcasts
  a_r6_sat_hold : assert property (@(posedge clk) disable iff (rst)
    (run_q == LIMIT && !win_clear && frame_valid && frame_bcast) |=> run_q == LIMIT);

  // R5: a non-broadcast frame empties the run
  a_r5_clear_on_other : assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !frame_bcast) |=> run_q == '0);

  // R8: a clear colliding with a broadcast leaves a run of one
  a_r8_clear_then_count : assert property (@(posedge clk) disable iff (rst)
    (win_clear && frame_valid && frame_bcast) |=> run_q == CW'(1));
endmodule

// File: rtl/bcast_storm_filter.sv
module bcast_storm_filter #(
  parameter int ADDR_W       = 48,
  parameter int RUN_LIMIT    = 64,
  parameter int WINDOW_TICKS = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_en,
  input  logic              tick,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_da,
  output logic              dec_valid,
  output logic              dec_drop
);
  import bsf_pkg::*;

  logic         en_q;
  logic         is_bcast;
  logic         win_clear;
  logic         over_limit;
  bsf_verdict_t verdict_q;

  // Strap latch: follows the pin only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) en_q <= strap_en;
  end

  bsf_addr_class #(.ADDR_W(ADDR_W)) u_class (
    .addr     (frm_da),
    .is_bcast (is_bcast)
  );

  bsf_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .win_clear (win_clear)
  );

  bsf_run_counter #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk         (clk),
    .rst         (rst),
    .win_clear   (win_clear),
    .frame_valid (frm_valid),
    .frame_bcast (is_bcast),
    .over_limit  (over_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_q <= '0;
    end else begin
      verdict_q.valid <= frm_valid;
      verdict_q.drop  <= frm_valid && en_q && is_bcast && over_limit;
    end
  end

  assign dec_valid = verdict_q.valid;
  assign dec_drop  = verdict_q.drop;

  // R1: a disabled filter never drops
  a_r1_off_no_drop : assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !dec_drop);

  // R2: the captured strap is frozen outside reset
  a_r2_strap_frozen : assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(en_q));

  // R5: non-broadcast frames always pass
  a_r5_other_passes : assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !is_bcast) |=> !dec_drop);

  // R9: a decision follows each frame by exactly one cycle
  a_r9_valid_follows : assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> dec_valid);

  // R9: no decision without a frame
  a_r9_no_spurious : assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !dec_valid && !dec_drop);
endmodule

// File: tb/bcast_storm_filter_test.sv
`timescale 1ns/1ps
module bcast_storm_filter_test;
  localparam int AW = 48;
  localparam int L  = 4;
  localparam int W  = 6;
  localparam logic [AW-1:0] BC = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_en = 1'b0;
  logic tick = 1'b0;
  logic frm_valid = 1'b0;
  logic [AW-1:0] frm_da = '0;
  logic dec_valid, dec_drop;

  int checks = 0;
  int failures = 0;
  int m_cnt, m_tk;
  bit m_en;

  always #4 clk = ~clk;

  bcast_storm_filter #(.ADDR_W(AW), .RUN_LIMIT(L), .WINDOW_TICKS(W)) uut (
    .clk(clk), .rst(rst), .strap_en(strap_en), .tick(tick),
    .frm_valid(frm_valid), .frm_da(frm_da),
    .dec_valid(dec_valid), .dec_drop(dec_drop)
  );

  task automatic check(input string tag, input logic v, input logic d,
                       input logic ev, input logic ed);
    checks++;
    if (v !== ev || d !== ed) begin
      failures++;
      $display("FAIL %s: valid/drop actual=%b%b expected=%b%b", tag, v, d, ev, ed);
    end
  endtask

  // R10: reset with a given strap; the model restarts too
  task automatic do_reset(input bit en);
    @(negedge clk);
    rst = 1'b1; strap_en = en; frm_valid = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", dec_valid, dec_drop, 1'b0, 1'b0);
    rst = 1'b0;
    m_cnt = 0; m_tk = 0; m_en = en;
    @(posedge clk); #1;
    check("R10", dec_valid, dec_drop, 1'b0, 1'b0);
  endtask

  // Drive one cycle, predict the verdict arithmetically, sample after the edge.
  task automatic step(input bit v, input logic [AW-1:0] da, input bit tk, input string tag);
    bit clr, bc, ed;
    int eff;
    @(negedge clk);
    frm_valid = v; frm_da = da; tick = tk;
    clr = tk && (m_tk == W - 1);
    if (tk) m_tk = clr ? 0 : m_tk + 1;
    eff = clr ? 0 : m_cnt;
    bc = (da == BC);
    ed = v && m_en && bc && (eff >= L);
    if (v) m_cnt = bc ? ((eff + 1 > L) ? L : eff + 1) : 0;
    else   m_cnt = eff;
    @(posedge clk); #1;
    check(tag, dec_valid, dec_drop, v, ed);
  endtask

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: strap low, long broadcast run never dropped
    do_reset(1'b0);
    for (int i = 0; i < 12; i++) step(1, BC, 0, "R1");

    // R4: run-length sweep with the filter on
    do_reset(1'b1);
    for (int n = 1; n <= L + 4; n++) begin
      for (int i = 0; i < n; i++) step(1, BC, 0, "R4");
      step(1, 48'h0000_1234_5678, 0, "R5");
    end

    // R3: every single-bit hole makes a non-broadcast that passes and clears
    for (int b = 0; b < AW; b++) begin
      for (int i = 0; i < L + 1; i++) step(1, BC, 0, "R3");
      step(1, BC ^ (48'd1 << b), 0, "R3");
      step(1, BC, 0, "R5");
    end

    // R6: long run stays dropped well past the counter's binary range
    for (int i = 0; i < 20; i++) step(1, BC, 0, "R6");

    // R2: strap changes after reset change nothing
    strap_en = 1'b0;
    for (int i = 0; i < 4; i++) step(1, BC, 0, "R2");

    // R9: idle cycles give no decision
    for (int i = 0; i < 3; i++) step(0, BC, 0, "R9");

    // R8: saturate, walk the window to its last slot, collide a broadcast
    do_reset(1'b1);
    for (int i = 0; i < L + 1; i++) step(1, BC, 0, "R8");
    for (int i = 0; i < W - 1; i++) step(0, '0, 1, "R7");
    step(1, BC, 1, "R8");
    step(1, BC, 0, "R8");

    // R7: window clears from ticks alone, then mixed tick/frame patterns
    for (int i = 0; i < L + 1; i++) step(1, BC, 0, "R7");
    for (int i = 0; i < W; i++) step(0, '0, 1, "R7");
    step(1, BC, 0, "R7");
    for (int i = 0; i < 40; i++) step(1, BC, 1, "R8");
    for (int i = 0; i < 60; i++) step((i % 3) != 2, BC, (i % 2) == 0, "R7");

    // R1: disabled filter with ticks and collisions
    do_reset(1'b0);
    for (int i = 0; i < 20; i++) step(1, BC, (i % 4) == 0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule